// File: doc/BRIEF.md
# J1850 Transmit Byte Sequencer

This block turns bytes written by a host into a serial bit stream for a J1850-style link. The bits go to a downstream symbol encoder. There are two byte stages: a shift register holding the byte now on the wire, and a one-byte holding stage the host may fill while that byte is still being sent. Each outgoing bit is offered to the encoder with a one-cycle `bit_start` strobe and a `bit_val` level. The encoder answers with `bit_done` once it has finished driving that symbol. Pulse widths, arbitration and reception are handled elsewhere.

When the host requests end-of-data, the sequencer first drains every byte still queued. It then appends one 8-bit CRC over all data bytes of the frame. The CRC uses polynomial 0x1D, a preset of 0xFF, and is sent inverted. For an in-frame response the block places a normalization bit ahead of the first data bit. The polarity of that bit depends on a format-select input and on whether the response will end with a CRC. A transmit-empty flag tells the host when it may write. A one-cycle pulse marks the first CRC bit, so the end-of-data request can be retired. An error input aborts the frame at once.

Top module: `j1850_tx_seq`

## Requirements
- R1: After a synchronous reset, `tx_empty`=1, `busy`=0, `bit_start`=0 and `crc_start`=0.
- R2: Data bytes go out most significant bit first, one bit per `bit_start` pulse. A new `bit_start` appears on the clock edge after `bit_done` is sampled high. `bit_start` is only ever high while `busy`=1.
- R3: A write (`wr_en`=1) is taken only when `tx_empty`=1; a write while `tx_empty`=0 is dropped and never sent. A held byte follows the previous byte with no idle bit between them.
- R4: After `eod_req` is accepted, exactly one CRC byte follows the last pending data byte. This includes a byte still held in the holding stage when the request arrived. No further bits follow the CRC.
- R5: The CRC has polynomial x^8+x^4+x^3+x^2+1 (0x1D) and preset 0xFF. It covers every data byte since the last CRC or error, including bytes written after the queue ran dry mid-frame. It is sent bitwise inverted, most significant bit first.
- R6: `crc_start` is a one-cycle pulse that coincides with the `bit_start` of the first CRC bit.
- R7: If `ifr_en`=1 when a frame's first byte starts, one normalization bit goes out before the first data bit. With `nb_fmt`=0 its value equals `ifr_crc`; with `nb_fmt`=1 its value is the inverse of `ifr_crc`. If `ifr_en`=0, no such bit is sent, and no such bit is sent in the middle of a frame.
- R8: `tx_empty`=1 exactly when the holding stage is free and no end-of-data request is pending. An `eod_req` while idle with no frame open and nothing queued is ignored.
- R9: `err`=1 aborts on the next edge: `busy`=0, `tx_empty`=1, no further bits, and the CRC is preset again for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | DATA_W | Host byte |
| eod_req | input | 1 | End-of-data request pulse |
| ifr_en | input | 1 | Frame is an in-frame response (send normalization bit) |
| nb_fmt | input | 1 | Normalization bit format select |
| ifr_crc | input | 1 | Response ends with a CRC byte |
| err | input | 1 | Abort and flush |
| bit_done | input | 1 | Encoder finished the current bit |
| bit_start | output | 1 | One-cycle strobe: new bit on `bit_val` |
| bit_val | output | 1 | Value of the current bit |
| crc_start | output | 1 | Pulse with the first CRC bit |
| tx_empty | output | 1 | Holding stage may accept a byte |
| busy | output | 1 | A bit sequence is in progress |

## Verification
Every output is a register. A write, an end-of-data request or an error therefore shows on `tx_empty` and `busy` one edge after it is sampled. A held byte is loaded and its first `bit_start` raised one edge after that. Each later bit strobe follows one edge after `bit_done`. The bench drives inputs and samples outputs on the falling edge. Its encoder model records a bit on the falling edge where `bit_start` is seen. It raises `bit_done` two falling edges later and looks for the next strobe one falling edge after that. Flag checks are made one falling edge after the stimulus edge, or after the stream has settled.

// File: rtl/j1850_tx_pkg.sv
package j1850_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NB   = 2'd1,
    ST_DATA = 2'd2,
    ST_CRC  = 2'd3
  } tx_state_e;

endpackage

// File: rtl/j1850_tx_shadow.sv
module j1850_tx_shadow #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full_q,
  output logic              full_n,
  output logic [DATA_W-1:0] data_q
);

  always_comb begin
    if (flush)     full_n = 1'b0;
    else if (wr)   full_n = 1'b1;
    else if (take) full_n = 1'b0;
    else           full_n = full_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_n;
      if (wr && !flush) data_q <= wr_data;
    end
  end

endmodule

// File: rtl/j1850_tx_crc.sv
module j1850_tx_crc #(
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] POLY   = 8'h1D,
  parameter logic [DATA_W-1:0] INIT   = 8'hFF,
  parameter bit              INVERT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              upd,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] crc_tx
);

  logic [DATA_W-1:0] crc_q;
  logic [DATA_W-1:0] crc_next;

  function automatic logic [DATA_W-1:0] fold_byte(input logic [DATA_W-1:0] c_in,
                                                  input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] c;
    logic              fb;
    c = c_in;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[DATA_W-1] ^ d[i];
      c  = {c[DATA_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return c;
  endfunction

  assign crc_next = fold_byte(crc_q, data);

  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= INIT;
    else if (upd)     crc_q <= crc_next;
  end

  generate
    if (INVERT) begin : g_inv
      assign crc_tx = ~crc_q;
    end else begin : g_raw
      assign crc_tx = crc_q;
    end
  endgenerate

endmodule

// File: rtl/j1850_tx_nbsel.sv
module j1850_tx_nbsel (
  input  logic fmt_sel,
  input  logic ends_crc,
  output logic nb_val
);

  always_comb begin
    case ({fmt_sel, ends_crc})
      2'b00:   nb_val = 1'b0;
      2'b01:   nb_val = 1'b1;
      2'b10:   nb_val = 1'b1;
      default: nb_val = 1'b0;
    endcase
  end

endmodule

// File: rtl/j1850_tx_seq.sv
module j1850_tx_seq #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] CRC_POLY = 8'h1D,
  parameter logic [DATA_W-1:0] CRC_INIT = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              eod_req,
  input  logic              ifr_en,
  input  logic              nb_fmt,
  input  logic              ifr_crc,
  input  logic              err,
  input  logic              bit_done,
  output logic              bit_start,
  output logic              bit_val,
  output logic              crc_start,
  output logic              tx_empty,
  output logic              busy
);
  import j1850_tx_pkg::*;

  localparam int              CNT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  tx_state_e         state_q, st_n;
  logic [DATA_W-1:0] shreg_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              eod_q, eod_n;
  logic              open_q, open_n;
  logic              bs_q, bs_n;
  logic              bv_q, bv_n;
  logic              cs_q, cs_n;
  logic              empty_q, empty_n;
  logic              busy_q, busy_n;

  logic              wr_acc;
  logic              take;
  logic              crc_clr;
  logic              hold_full, hold_full_n;
  logic [DATA_W-1:0] hold_data;
  logic [DATA_W-1:0] crc_tx;
  logic              nb_val;

  assign wr_acc = wr_en && empty_q && !err;

  j1850_tx_shadow #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .flush   (err),
    .wr      (wr_acc),
    .wr_data (wr_data),
    .take    (take),
    .full_q  (hold_full),
    .full_n  (hold_full_n),
    .data_q  (hold_data)
  );

  j1850_tx_crc #(
    .DATA_W (DATA_W),
    .POLY   (CRC_POLY),
    .INIT   (CRC_INIT),
    .INVERT (1'b1)
  ) u_crc (
    .clk    (clk),
    .rst    (rst),
    .clear  (crc_clr),
    .upd    (take),
    .data   (hold_data),
    .crc_tx (crc_tx)
  );

  j1850_tx_nbsel u_nb (
    .fmt_sel  (nb_fmt),
    .ends_crc (ifr_crc),
    .nb_val   (nb_val)
  );

  always_comb begin
    st_n    = state_q;
    sh_n    = shreg_q;
    cnt_n   = cnt_q;
    open_n  = open_q;
    bs_n    = 1'b0;
    bv_n    = bv_q;
    cs_n    = 1'b0;
    take    = 1'b0;
    crc_clr = 1'b0;
    eod_n   = eod_q;

    if (eod_req && (state_q != ST_IDLE || open_q || hold_full)) eod_n = 1'b1;

    case (state_q)
      ST_IDLE: begin
        if (hold_full) begin
          take   = 1'b1;
          sh_n   = hold_data;
          cnt_n  = '0;
          bs_n   = 1'b1;
          open_n = 1'b1;
          if (!open_q && ifr_en) begin
            st_n = ST_NB;
            bv_n = nb_val;
          end else begin
            st_n = ST_DATA;
            bv_n = hold_data[DATA_W-1];
          end
        end else if (eod_q && open_q) begin
          st_n  = ST_CRC;
          sh_n  = crc_tx;
          cnt_n = '0;
          bs_n  = 1'b1;
          bv_n  = crc_tx[DATA_W-1];
          cs_n  = 1'b1;
          eod_n = 1'b0;
        end
      end
      ST_NB: begin
        if (bit_done) begin
          st_n  = ST_DATA;
          cnt_n = '0;
          bs_n  = 1'b1;
          bv_n  = shreg_q[DATA_W-1];
        end
      end
      ST_DATA: begin
        if (bit_done) begin
          if (cnt_q != LAST_BIT) begin
            cnt_n = cnt_q + CNT_W'(1);
            sh_n  = {shreg_q[DATA_W-2:0], 1'b0};
            bs_n  = 1'b1;
            bv_n  = shreg_q[DATA_W-2];
          end else if (hold_full) begin
            take  = 1'b1;
            sh_n  = hold_data;
            cnt_n = '0;
            bs_n  = 1'b1;
            bv_n  = hold_data[DATA_W-1];
          end else if (eod_q) begin
            st_n  = ST_CRC;
            sh_n  = crc_tx;
            cnt_n = '0;
            bs_n  = 1'b1;
            bv_n  = crc_tx[DATA_W-1];
            cs_n  = 1'b1;
            eod_n = 1'b0;
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      default: begin
        if (bit_done) begin
          if (cnt_q != LAST_BIT) begin
            cnt_n = cnt_q + CNT_W'(1);
            sh_n  = {shreg_q[DATA_W-2:0], 1'b0};
            bs_n  = 1'b1;
            bv_n  = shreg_q[DATA_W-2];
          end else begin
            st_n    = ST_IDLE;
            open_n  = 1'b0;
            crc_clr = 1'b1;
          end
        end
      end
    endcase

    if (err) begin
      st_n    = ST_IDLE;
      cnt_n   = '0;
      open_n  = 1'b0;
      bs_n    = 1'b0;
      cs_n    = 1'b0;
      take    = 1'b0;
      crc_clr = 1'b1;
      eod_n   = 1'b0;
    end

    empty_n = !hold_full_n && !eod_n;
    busy_n  = (st_n != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      eod_q   <= 1'b0;
      open_q  <= 1'b0;
      bs_q    <= 1'b0;
      bv_q    <= 1'b0;
      cs_q    <= 1'b0;
      empty_q <= 1'b1;
      busy_q  <= 1'b0;
    end else begin
      state_q <= st_n;
      shreg_q <= sh_n;
      cnt_q   <= cnt_n;
      eod_q   <= eod_n;
      open_q  <= open_n;
      bs_q    <= bs_n;
      bv_q    <= bv_n;
      cs_q    <= cs_n;
      empty_q <= empty_n;
      busy_q  <= busy_n;
    end
  end

  assign bit_start = bs_q;
  assign bit_val   = bv_q;
  assign crc_start = cs_q;
  assign tx_empty  = empty_q;
  assign busy      = busy_q;

endmodule

// File: rtl/j1850_tx_seq_chk.sv
module j1850_tx_seq_chk (
  input logic clk,
  input logic rst,
  input logic err,
  input logic bit_start,
  input logic crc_start,
  input logic tx_empty,
  input logic busy
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (tx_empty && !busy && !bit_start && !crc_start));

  // R2
  strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bit_start |-> busy);

  // R6
  crc_with_bit_chk: assert property (@(posedge clk) disable iff (rst)
    crc_start |-> bit_start);

  // R6
  crc_single_chk: assert property (@(posedge clk) disable iff (rst)
    crc_start |=> !crc_start);

  // R9
  err_flush_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> (!busy && tx_empty && !bit_start && !crc_start));

endmodule

bind j1850_tx_seq j1850_tx_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .err       (err),
  .bit_start (bit_start),
  .crc_start (crc_start),
  .tx_empty  (tx_empty),
  .busy      (busy)
);

// File: tb/tb_j1850_tx_seq.sv
module tb_j1850_tx_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       eod_req = 1'b0;
  logic       ifr_en = 1'b0;
  logic       nb_fmt = 1'b0;
  logic       ifr_crc = 1'b0;
  logic       err = 1'b0;
  logic       bit_done;
  logic       bit_start, bit_val, crc_start, tx_empty, busy;

  always #2 clk = ~clk;  // 250 MHz

  j1850_tx_seq dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .eod_req(eod_req),
    .ifr_en(ifr_en), .nb_fmt(nb_fmt), .ifr_crc(ifr_crc), .err(err),
    .bit_done(bit_done), .bit_start(bit_start), .bit_val(bit_val),
    .crc_start(crc_start), .tx_empty(tx_empty), .busy(busy)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic got_bits [64];
  logic exp_bits [64];
  int   nbits = 0;
  int   exp_n = 0;
  int   crc_idx = -1;

  // {count[28:27], b0[26:19], b1[18:11], b2[10:3], ifr[2], fmt[1], ends_crc[0]}
  localparam logic [28:0] VEC [5] = '{
    {2'd1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    {2'd2, 8'hFF, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0},
    {2'd3, 8'h12, 8'h34, 8'h56, 1'b1, 1'b0, 1'b1},
    {2'd2, 8'hA5, 8'h5A, 8'h00, 1'b1, 1'b0, 1'b0},
    {2'd1, 8'hC3, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[7] != d[i]) r = (r << 1) ^ 8'h1D;
      else              r = r << 1;
    end
    return r;
  endfunction

  // Encoder model: records each bit, answers bit_done two falling edges later.
  initial begin
    bit_done = 1'b0;
    begin
      bit pend;
      int wcnt;
      pend = 1'b0;
      wcnt = 0;
      forever begin
        @(negedge clk);
        bit_done = 1'b0;
        if (crc_start) crc_idx = nbits;
        if (bit_start) begin
          if (nbits < 64) got_bits[nbits] = bit_val;
          nbits++;
          pend = 1'b1;
          wcnt = 0;
        end else if (pend) begin
          wcnt++;
          if (wcnt == 2) begin
            bit_done = 1'b1;
            pend = 1'b0;
          end
        end
      end
    end
  end

  task automatic write_byte(input logic [7:0] b);
    while (!tx_empty) @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_eod();
    eod_req = 1'b1;
    @(negedge clk);
    eod_req = 1'b0;
  endtask

  task automatic wait_bits(input int target);
    int t;
    t = 0;
    while (nbits < target && t < 4000) begin
      @(negedge clk);
      t++;
    end
  endtask

  function automatic logic [31:0] pack(input bit from_got, input int lo, input int hi);
    logic [31:0] v;
    v = '0;
    for (int i = lo; i < hi; i++) v = {v[30:0], (from_got ? got_bits[i] : exp_bits[i])};
    return v;
  endfunction

  task automatic clear_capture();
    nbits = 0;
    crc_idx = -1;
  endtask

  task automatic add_byte_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      exp_bits[exp_n] = b[i];
      exp_n++;
    end
  endtask

  task automatic check_stream(input bit has_nb, input string name);
    int dlo;
    dlo = has_nb ? 1 : 0;
    chk(nbits == exp_n, {"R4 bit count ", name}, nbits, exp_n);
    if (nbits == exp_n) begin
      if (has_nb) chk(got_bits[0] == exp_bits[0], {"R7 normalization bit ", name},
                      int'(got_bits[0]), int'(exp_bits[0]));
      chk(pack(1, dlo, exp_n - 8) == pack(0, dlo, exp_n - 8), {"R2 data bits ", name},
          int'(pack(1, dlo, exp_n - 8)), int'(pack(0, dlo, exp_n - 8)));
      chk(pack(1, exp_n - 8, exp_n) == pack(0, exp_n - 8, exp_n), {"R5 crc bits ", name},
          int'(pack(1, exp_n - 8, exp_n)), int'(pack(0, exp_n - 8, exp_n)));
    end
    chk(crc_idx == exp_n - 8, {"R6 crc_start position ", name}, crc_idx, exp_n - 8);
    chk(tx_empty == 1'b1 && busy == 1'b0, {"R8 idle flags after frame ", name},
        int'({tx_empty, busy}), 2);
  endtask

  task automatic run_frame(input int n, input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input logic ifr, input logic fmt,
                           input logic ec, input string name);
    logic [7:0] bytes [3];
    logic [7:0] c;
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
    c = 8'hFF;
    exp_n = 0;
    if (ifr) begin
      exp_bits[0] = fmt ? !ec : ec;
      exp_n = 1;
    end
    for (int j = 0; j < n; j++) begin
      c = ref_crc_step(c, bytes[j]);
      add_byte_bits(bytes[j]);
    end
    add_byte_bits(~c);
    ifr_en = ifr; nb_fmt = fmt; ifr_crc = ec;
    @(negedge clk);
    clear_capture();
    for (int j = 0; j < n; j++) write_byte(bytes[j]);
    pulse_eod();
    wait_bits(exp_n);
    repeat (20) @(negedge clk);
    check_stream(ifr, name);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] c;
    int n0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(tx_empty && !busy && !bit_start && !crc_start, "R1 reset state",
        int'({tx_empty, busy, bit_start, crc_start}), 8);

    // Vector table walk
    for (int v = 0; v < 5; v++) begin
      run_frame(int'(VEC[v][28:27]), VEC[v][26:19], VEC[v][18:11], VEC[v][10:3],
                VEC[v][2], VEC[v][1], VEC[v][0], $sformatf("vec%0d", v));
    end

    // R8: end-of-data with no open frame is ignored
    ifr_en = 1'b0;
    clear_capture();
    pulse_eod();
    chk(tx_empty == 1'b1, "R8 idle eod ignored (tx_empty)", int'(tx_empty), 1);
    repeat (30) @(negedge clk);
    chk(nbits == 0 && !busy, "R8 idle eod ignored (no bits)", nbits, 0);

    // R3: write while holding stage full is dropped
    clear_capture();
    write_byte(8'h81);
    write_byte(8'h7E);
    chk(tx_empty == 1'b0, "R3 tx_empty low while byte held", int'(tx_empty), 0);
    wr_en = 1'b1; wr_data = 8'hEE;
    @(negedge clk);
    wr_en = 1'b0;
    pulse_eod();
    c = ref_crc_step(ref_crc_step(8'hFF, 8'h81), 8'h7E);
    exp_n = 0;
    add_byte_bits(8'h81); add_byte_bits(8'h7E); add_byte_bits(~c);
    wait_bits(exp_n);
    repeat (20) @(negedge clk);
    check_stream(1'b0, "R3 dropped write");

    // R5/R7: queue runs dry mid-frame, CRC continues, no second normalization bit
    ifr_en = 1'b1; nb_fmt = 1'b1; ifr_crc = 1'b1;
    @(negedge clk);
    clear_capture();
    write_byte(8'h55);
    wait_bits(9);
    repeat (20) @(negedge clk);
    chk(tx_empty && !busy, "R5 dry queue idles", int'({tx_empty, busy}), 2);
    write_byte(8'hAA);
    pulse_eod();
    c = ref_crc_step(ref_crc_step(8'hFF, 8'h55), 8'hAA);
    exp_n = 1;
    exp_bits[0] = 1'b0;
    add_byte_bits(8'h55); add_byte_bits(8'hAA); add_byte_bits(~c);
    wait_bits(exp_n);
    repeat (20) @(negedge clk);
    check_stream(1'b1, "R5 dry-run frame");

    // R9: error abort mid-byte
    ifr_en = 1'b0;
    @(negedge clk);
    clear_capture();
    write_byte(8'hA5);
    write_byte(8'h3C);
    wait_bits(3);
    err = 1'b1;
    @(negedge clk);
    err = 1'b0;
    chk(!busy && tx_empty, "R9 abort flags", int'({busy, tx_empty}), 1);
    n0 = nbits;
    repeat (40) @(negedge clk);
    chk(nbits == n0, "R9 no bits after abort", nbits, n0);
    run_frame(1, 8'h12, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, "R9 fresh CRC after abort");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule